// File: doc/BRIEF.md
# Predicated Register File with Trust Shadow

This block stores eight 32-bit general-purpose registers and two one-bit predicate registers, and it keeps one trust label beside every stored bit. A label of 1 marks the bit as untrusted and a label of 0 marks it as trusted. Conditional work is done without branching. Every write names a predicate, and the data lands only when that predicate holds 1. The program counter is never steered by data, so it always stays trusted.

A write is classified into one of four actions: SKIP (no request, or a trusted predicate holding 0), COMMIT (a trusted predicate holding 1: data and labels both land), TAINT_COMMIT (an untrusted predicate holding 1: data lands and every label of the destination becomes untrusted) and TAINT_HOLD (an untrusted predicate holding 0: data stays and every label of the destination becomes untrusted). With the last two actions, an observer cannot learn the predicate's value from the destination's labels.

A separate one-bit port writes the predicates together with their labels. Two combinational read ports return a register's value and its labels together. The current predicate values and labels are also visible on output pins.

Top module: `tpr_regfile`

## Requirements
- R1: A synchronous active-high `rst` clears all register data and predicate values to 0 and sets every label to 0 (trusted) at the next rising edge.
- R2: With `wr_req`=1 and the selected predicate trusted (label 0) and holding 1, register `wr_idx` takes `wr_data` and `wr_label` at the next edge.
- R3: With `wr_req`=1 and the selected predicate trusted and holding 0, the data and labels of register `wr_idx` stay unchanged.
- R4: With `wr_req`=1 and the selected predicate untrusted (label 1) and holding 1, register `wr_idx` takes `wr_data`, and all 32 of its labels become 1 whatever `wr_label` is.
- R5: With `wr_req`=1 and the selected predicate untrusted and holding 0, the data of register `wr_idx` stays unchanged and all 32 of its labels become 1.
- R6: Registers other than `wr_idx` never change on a write, and with `wr_req`=0 no register changes.
- R7: With `pw_req`=1, predicate `pw_idx` takes `pw_val` and label `pw_label` at the next edge, and the other predicate is unchanged. `pred_val[i]` and `pred_label[i]` show predicate i.
- R8: When a predicate write and a register write happen in the same cycle, the register write is governed by the predicate value and label held before that edge.
- R9: Each read port returns, in the same cycle, the data and labels of the register its index selects. The two ports are independent and may select the same register.
- R10: `wr_psel` selects the governing predicate by its index: 0 picks predicate 0 and 1 picks predicate 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Register write request |
| wr_idx | input | 3 | Destination register index |
| wr_psel | input | 1 | Index of the governing predicate |
| wr_data | input | 32 | Write data |
| wr_label | input | 32 | Per-bit labels of the write data (1 = untrusted) |
| pw_req | input | 1 | Predicate write request |
| pw_idx | input | 1 | Predicate index to write |
| pw_val | input | 1 | Predicate value to write |
| pw_label | input | 1 | Label of the predicate value |
| ra_idx | input | 3 | Read port A index |
| ra_data | output | 32 | Read port A data |
| ra_label | output | 32 | Read port A labels |
| rb_idx | input | 3 | Read port B index |
| rb_data | output | 32 | Read port B data |
| rb_label | output | 32 | Read port B labels |
| pred_val | output | 2 | Current predicate values |
| pred_label | output | 2 | Current predicate labels |

## Verification
The bench targets an untrusted predicate holding 0. A design that skips the write entirely in that case leaves the labels trusted and so leaks the predicate's value, and the bench sees those trusted labels. A design that writes the data in that case shows the new value. The bench also drives an untrusted predicate holding 1 with a mostly trusted `wr_label`, which catches a design that copies the incoming labels instead of forcing them all to 1. Same-cycle predicate and register writes catch a design that forwards the new predicate value. A run of random writes with every register compared on every clock catches writes that reach the wrong index or fire without `wr_req`.

// File: rtl/tpr_pkg.sv
package tpr_pkg;
    localparam int unsigned GPR_COUNT  = 8;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned PRED_COUNT = 2;

    // Per-write action chosen from request, predicate value and predicate label
    typedef enum logic [1:0] {
        WR_SKIP         = 2'd0,
        WR_COMMIT       = 2'd1,
        WR_TAINT_COMMIT = 2'd2,
        WR_TAINT_HOLD   = 2'd3
    } wr_action_e;
endpackage

// File: rtl/tpr_wr_classify.sv
module tpr_wr_classify
    import tpr_pkg::*;
(
    input  logic       req_i,
    input  logic       pval_i,
    input  logic       plbl_i,
    output wr_action_e act_o
);
    always_comb begin
        act_o = WR_SKIP;
        unique case ({req_i, plbl_i, pval_i})
            3'b100:  act_o = WR_SKIP;
            3'b101:  act_o = WR_COMMIT;
            3'b110:  act_o = WR_TAINT_HOLD;
            3'b111:  act_o = WR_TAINT_COMMIT;
            default: act_o = WR_SKIP;
        endcase
    end
endmodule

// File: rtl/tpr_pred_bank.sv
module tpr_pred_bank #(
    parameter int unsigned P  = 2,
    parameter int unsigned PW = (P > 1) ? $clog2(P) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pw_req_i,
    input  logic [PW-1:0] pw_idx_i,
    input  logic          pw_val_i,
    input  logic          pw_lbl_i,
    input  logic [PW-1:0] psel_i,
    output logic [P-1:0]  val_o,
    output logic [P-1:0]  lbl_o,
    output logic          sel_val_o,
    output logic          sel_lbl_o
);
    logic [P-1:0] val_q;
    logic [P-1:0] lbl_q;

    for (genvar g = 0; g < P; g++) begin : g_pred
        logic hit;
        assign hit = pw_req_i && (pw_idx_i == PW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q[g] <= 1'b0;
                lbl_q[g] <= 1'b0;
            end else if (hit) begin
                val_q[g] <= pw_val_i;
                lbl_q[g] <= pw_lbl_i;
            end
        end

        // R7: a predicate write lands with its label
        p_pred_write_r7: assert property (@(posedge clk) disable iff (rst)
            (pw_req_i && pw_idx_i == PW'(g)) |=>
                (val_o[g] == $past(pw_val_i) && lbl_o[g] == $past(pw_lbl_i)));
        // R7: other predicates hold
        p_pred_hold_r7: assert property (@(posedge clk) disable iff (rst)
            !(pw_req_i && pw_idx_i == PW'(g)) |=>
                ($stable(val_o[g]) && $stable(lbl_o[g])));
    end

    assign val_o     = val_q;
    assign lbl_o     = lbl_q;
    assign sel_val_o = val_q[psel_i];
    assign sel_lbl_o = lbl_q[psel_i];
endmodule

// File: rtl/tpr_gpr_bank.sv
module tpr_gpr_bank
    import tpr_pkg::*;
#(
    parameter int unsigned N  = 8,
    parameter int unsigned W  = 32,
    parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_action_e        act_i,
    input  logic [IW-1:0]     idx_i,
    input  logic [W-1:0]      data_i,
    input  logic [W-1:0]      lbl_i,
    output logic [N-1:0][W-1:0] data_o,
    output logic [N-1:0][W-1:0] lbl_o
);
    for (genvar g = 0; g < N; g++) begin : g_reg
        logic         sel;
        logic [W-1:0] d_q;
        logic [W-1:0] l_q;

        assign sel = (idx_i == IW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                d_q <= '0;
                l_q <= '0;
            end else if (sel) begin
                unique case (act_i)
                    WR_SKIP: ;
                    WR_COMMIT: begin
                        d_q <= data_i;
                        l_q <= lbl_i;
                    end
                    WR_TAINT_COMMIT: begin
                        d_q <= data_i;
                        l_q <= '1;
                    end
                    WR_TAINT_HOLD: begin
                        l_q <= '1;
                    end
                    default: ;
                endcase
            end
        end

        assign data_o[g] = d_q;
        assign lbl_o[g]  = l_q;
    end
endmodule

// File: rtl/tpr_read_port.sv
module tpr_read_port #(
    parameter int unsigned N  = 8,
    parameter int unsigned W  = 32,
    parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0][W-1:0] data_i,
    input  logic [N-1:0][W-1:0] lbl_i,
    input  logic [IW-1:0]       idx_i,
    output logic [W-1:0]        data_o,
    output logic [W-1:0]        lbl_o
);
    // Value and label leave through the same select so they stay paired
    assign data_o = data_i[idx_i];
    assign lbl_o  = lbl_i[idx_i];
endmodule

// File: rtl/tpr_regfile.sv
module tpr_regfile
    import tpr_pkg::*;
#(
    parameter int unsigned NUM_GPR  = GPR_COUNT,
    parameter int unsigned DATA_W   = WORD_W,
    parameter int unsigned NUM_PRED = PRED_COUNT,
    localparam int unsigned IDX_W   = (NUM_GPR > 1) ? $clog2(NUM_GPR) : 1,
    localparam int unsigned PSEL_W  = (NUM_PRED > 1) ? $clog2(NUM_PRED) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PSEL_W-1:0] wr_psel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] wr_label,
    input  logic              pw_req,
    input  logic [PSEL_W-1:0] pw_idx,
    input  logic              pw_val,
    input  logic              pw_label,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [DATA_W-1:0] ra_data,
    output logic [DATA_W-1:0] ra_label,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [DATA_W-1:0] rb_data,
    output logic [DATA_W-1:0] rb_label,
    output logic [NUM_PRED-1:0] pred_val,
    output logic [NUM_PRED-1:0] pred_label
);
    logic       sel_val;
    logic       sel_lbl;
    wr_action_e act;
    logic [NUM_GPR-1:0][DATA_W-1:0] gpr_d;
    logic [NUM_GPR-1:0][DATA_W-1:0] gpr_l;

    tpr_pred_bank #(.P(NUM_PRED), .PW(PSEL_W)) u_pred (
        .clk(clk), .rst(rst),
        .pw_req_i(pw_req), .pw_idx_i(pw_idx), .pw_val_i(pw_val), .pw_lbl_i(pw_label),
        .psel_i(wr_psel),
        .val_o(pred_val), .lbl_o(pred_label),
        .sel_val_o(sel_val), .sel_lbl_o(sel_lbl)
    );

    tpr_wr_classify u_cls (
        .req_i(wr_req), .pval_i(sel_val), .plbl_i(sel_lbl), .act_o(act)
    );

    tpr_gpr_bank #(.N(NUM_GPR), .W(DATA_W), .IW(IDX_W)) u_gpr (
        .clk(clk), .rst(rst),
        .act_i(act), .idx_i(wr_idx), .data_i(wr_data), .lbl_i(wr_label),
        .data_o(gpr_d), .lbl_o(gpr_l)
    );

    tpr_read_port #(.N(NUM_GPR), .W(DATA_W), .IW(IDX_W)) u_rd_a (
        .data_i(gpr_d), .lbl_i(gpr_l), .idx_i(ra_idx), .data_o(ra_data), .lbl_o(ra_label)
    );

    tpr_read_port #(.N(NUM_GPR), .W(DATA_W), .IW(IDX_W)) u_rd_b (
        .data_i(gpr_d), .lbl_i(gpr_l), .idx_i(rb_idx), .data_o(rb_data), .lbl_o(rb_label)
    );

    // Checks relating write ports and held predicate state to register state
    for (genvar g = 0; g < NUM_GPR; g++) begin : g_chk
        p_commit_r2: assert property (@(posedge clk) disable iff (rst)
            (wr_req && wr_idx == IDX_W'(g) && !pred_label[wr_psel] && pred_val[wr_psel]) |=>
                (gpr_d[g] == $past(wr_data) && gpr_l[g] == $past(wr_label)));
        p_trusted_zero_hold_r3: assert property (@(posedge clk) disable iff (rst)
            (wr_req && wr_idx == IDX_W'(g) && !pred_label[wr_psel] && !pred_val[wr_psel]) |=>
                ($stable(gpr_d[g]) && $stable(gpr_l[g])));
        p_taint_commit_r4: assert property (@(posedge clk) disable iff (rst)
            (wr_req && wr_idx == IDX_W'(g) && pred_label[wr_psel] && pred_val[wr_psel]) |=>
                (gpr_d[g] == $past(wr_data) && (&gpr_l[g])));
        p_taint_hold_r5: assert property (@(posedge clk) disable iff (rst)
            (wr_req && wr_idx == IDX_W'(g) && pred_label[wr_psel] && !pred_val[wr_psel]) |=>
                ($stable(gpr_d[g]) && (&gpr_l[g])));
        p_untouched_r6: assert property (@(posedge clk) disable iff (rst)
            !(wr_req && wr_idx == IDX_W'(g)) |=>
                ($stable(gpr_d[g]) && $stable(gpr_l[g])));
    end
endmodule

// File: tb/tpr_regfile_tb_top.sv
`timescale 1ns/100ps
module tpr_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_req;
    logic [2:0]  wr_idx;
    logic [0:0]  wr_psel;
    logic [31:0] wr_data;
    logic [31:0] wr_label;
    logic        pw_req;
    logic [0:0]  pw_idx;
    logic        pw_val;
    logic        pw_label;
    logic [2:0]  ra_idx;
    logic [31:0] ra_data;
    logic [31:0] ra_label;
    logic [2:0]  rb_idx;
    logic [31:0] rb_data;
    logic [31:0] rb_label;
    logic [1:0]  pred_val;
    logic [1:0]  pred_label;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference state
    logic [31:0] m_d [8];
    logic [31:0] m_l [8];
    logic        m_pv [2];
    logic        m_pl [2];

    always #5 clk = ~clk;

    tpr_regfile dut_i (
        .clk(clk), .rst(rst),
        .wr_req(wr_req), .wr_idx(wr_idx), .wr_psel(wr_psel),
        .wr_data(wr_data), .wr_label(wr_label),
        .pw_req(pw_req), .pw_idx(pw_idx), .pw_val(pw_val), .pw_label(pw_label),
        .ra_idx(ra_idx), .ra_data(ra_data), .ra_label(ra_label),
        .rb_idx(rb_idx), .rb_data(rb_data), .rb_label(rb_label),
        .pred_val(pred_val), .pred_label(pred_label)
    );

    task automatic idle_inputs();
        wr_req = 0; wr_idx = 0; wr_psel = 0; wr_data = 0; wr_label = 0;
        pw_req = 0; pw_idx = 0; pw_val = 0; pw_label = 0;
    endtask

    task automatic check_state(string tag);
        for (int i = 0; i < 8; i++) begin
            ra_idx = 3'(i);
            rb_idx = 3'((i + 3) % 8);
            #0.3;
            checks++;
            if (ra_data !== m_d[i] || ra_label !== m_l[i]) begin
                failures++;
                $display("FAIL %s port A r%0d: got d=%h l=%h exp d=%h l=%h",
                         tag, i, ra_data, ra_label, m_d[i], m_l[i]);
            end
            checks++;
            if (rb_data !== m_d[(i + 3) % 8] || rb_label !== m_l[(i + 3) % 8]) begin
                failures++;
                $display("FAIL %s R9 port B r%0d: got d=%h l=%h exp d=%h l=%h",
                         tag, (i + 3) % 8, rb_data, rb_label, m_d[(i + 3) % 8], m_l[(i + 3) % 8]);
            end
        end
        checks++;
        if (pred_val !== {m_pv[1], m_pv[0]} || pred_label !== {m_pl[1], m_pl[0]}) begin
            failures++;
            $display("FAIL %s R7 predicates: got v=%b l=%b exp v=%b l=%b",
                     tag, pred_val, pred_label, {m_pv[1], m_pv[0]}, {m_pl[1], m_pl[0]});
        end
    endtask

    // Called at a falling edge with inputs already driven
    task automatic step(string tag);
        logic [31:0] nd [8];
        logic [31:0] nl [8];
        logic        npv [2];
        logic        npl [2];
        logic        gv;
        logic        gl;
        for (int i = 0; i < 8; i++) begin nd[i] = m_d[i]; nl[i] = m_l[i]; end
        for (int i = 0; i < 2; i++) begin npv[i] = m_pv[i]; npl[i] = m_pl[i]; end
        if (rst) begin
            for (int i = 0; i < 8; i++) begin nd[i] = 0; nl[i] = 0; end
            for (int i = 0; i < 2; i++) begin npv[i] = 0; npl[i] = 0; end
        end else begin
            gv = m_pv[wr_psel];
            gl = m_pl[wr_psel];
            if (wr_req) begin
                if (gl) begin
                    nl[wr_idx] = 32'hFFFF_FFFF;
                    if (gv) nd[wr_idx] = wr_data;
                end else if (gv) begin
                    nd[wr_idx] = wr_data;
                    nl[wr_idx] = wr_label;
                end
            end
            if (pw_req) begin
                npv[pw_idx] = pw_val;
                npl[pw_idx] = pw_label;
            end
        end
        @(posedge clk);
        #1;
        for (int i = 0; i < 8; i++) begin m_d[i] = nd[i]; m_l[i] = nl[i]; end
        for (int i = 0; i < 2; i++) begin m_pv[i] = npv[i]; m_pl[i] = npl[i]; end
        check_state(tag);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic pred_write(int idx, logic v, logic l, string tag);
        pw_req = 1; pw_idx = 1'(idx); pw_val = v; pw_label = l;
        step(tag);
    endtask

    task automatic gpr_write(int idx, int psel, logic [31:0] d, logic [31:0] l, string tag);
        wr_req = 1; wr_idx = 3'(idx); wr_psel = 1'(psel); wr_data = d; wr_label = l;
        step(tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_d[i] = 'x; m_l[i] = 'x; end
        for (int i = 0; i < 2; i++) begin m_pv[i] = 'x; m_pl[i] = 'x; end
        idle_inputs();
        ra_idx = 0; rb_idx = 0;
        rst = 1;
        @(negedge clk);
        step("R1 reset");
        rst = 1;
        step("R1 reset");
        rst = 0;

        // Predicate setup: P0 = 1 trusted, P1 = 0 trusted
        pred_write(0, 1'b1, 1'b0, "R7 set P0");
        pred_write(1, 1'b0, 1'b0, "R7 set P1");
        gpr_write(3, 0, 32'hCAFE_0003, 32'h0000_00FF, "R2 commit via P0 (R10 psel=0)");
        gpr_write(3, 1, 32'h1111_2222, 32'hFFFF_0000, "R3 trusted zero keeps r3 (R10 psel=1)");
        gpr_write(4, 0, 32'hDEAD_BEEF, 32'h0000_0000, "R2 commit trusted labels");

        // Untrusted predicates
        pred_write(1, 1'b0, 1'b1, "R7 P1 untrusted zero");
        gpr_write(4, 1, 32'h5555_AAAA, 32'h0000_0000, "R5 taint hold r4");
        pred_write(0, 1'b1, 1'b1, "R7 P0 untrusted one");
        gpr_write(6, 0, 32'h0BAD_F00D, 32'h0000_0001, "R4 taint commit r6");

        // No request changes nothing
        wr_idx = 3; wr_psel = 0; wr_data = 32'h7777_7777; wr_label = 0;
        step("R6 idle write fields");

        // Same-cycle predicate and register write: old P1 (untrusted 0) governs
        pw_req = 1; pw_idx = 1; pw_val = 1; pw_label = 0;
        wr_req = 1; wr_idx = 2; wr_psel = 1; wr_data = 32'h2222_2222; wr_label = 0;
        step("R8 same-cycle old predicate");
        gpr_write(2, 1, 32'h3333_3333, 32'h0F0F_0F0F, "R8 new predicate in effect");

        // Both read ports on the same register
        ra_idx = 2; rb_idx = 2;
        #0.3;
        checks++;
        if (ra_data !== rb_data || ra_label !== rb_label || ra_data !== m_d[2]) begin
            failures++;
            $display("FAIL R9 same index: got a=%h b=%h exp %h", ra_data, rb_data, m_d[2]);
        end

        // Random traffic
        for (int n = 0; n < 300; n++) begin
            pw_req = ($urandom % 4) == 0;
            pw_idx = 1'($urandom);
            pw_val = 1'($urandom);
            pw_label = ($urandom % 3) == 0;
            wr_req = 1'($urandom);
            wr_idx = 3'($urandom);
            wr_psel = 1'($urandom);
            wr_data = $urandom;
            wr_label = $urandom;
            step("R6 random traffic");
        end

        // Reset again mid-run
        rst = 1;
        wr_req = 1; wr_idx = 5; wr_data = 32'h9999_9999;
        step("R1 reset mid-run");
        rst = 0;
        step("R1 after reset");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule